// File: doc/BRIEF.md
# Single-Word Peripheral-to-Memory DMA Controller

This controller copies one data word from a peripheral register into a memory location each time the peripheral asks for service. The processor first sets three configuration registers: a source address, a destination address and a control register that holds an enable bit. After that, the controller works on its own. It runs two handshakes that depend on each other. The first is a request/acknowledge pair with the peripheral. The second is a bus request/grant pair with the processor, which owns the shared synchronous bus.

When the peripheral raises its request, the controller asks the processor for the bus. The processor keeps running and stalls only if it needs the bus itself. Once the grant arrives, the controller acknowledges the peripheral and reads the source word. It then writes that word to the destination. In the cycle after the write it drops the bus request and the peripheral acknowledge together. A new transfer starts only after the peripheral has removed its request.

Top module: `dma_top`

## Requirements
- R1: During and right after reset, busReq, perAck, busRd and busWr are all low.
- R2: When the enable bit is set, the controller is armed and perReq is high in an idle cycle, busReq goes high in the next cycle while perAck stays low.
- R3: While busReq is high and busGrant has not yet been seen, the controller issues no bus read or write and keeps perAck low.
- R4: In the cycle after busGrant is seen high, perAck and busRd go high and busAddr carries the source address. That address is written with cfgSel=0.
- R5: Read data is taken from busRdata one cycle after the read cycle. In the cycle after that, busWr is high for one cycle, busAddr carries the destination address (written with cfgSel=1) and busWdata equals the word that was read.
- R6: In the cycle after the write, busReq and perAck fall in the same cycle.
- R7: When bit 0 of the control register (cfgSel=2) is clear, a high perReq is ignored and busReq stays low.
- R8: After a transfer, busReq stays low while perReq remains high. It rises again only after perReq has been seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfgData | input | ADDR_W | Configuration write data |
| perReq | input | 1 | Peripheral service request |
| perAck | output | 1 | Acknowledge to the peripheral |
| busReq | output | 1 | Bus request to the processor |
| busGrant | input | 1 | Bus grant from the processor |
| busAddr | output | ADDR_W | Bus address |
| busRd | output | 1 | Bus read strobe |
| busWr | output | 1 | Bus write strobe |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data, valid the cycle after busRd |

## Verification
The assertions assume the processor raises busGrant only while busReq is high and keeps it high until busReq falls. They also assume the bus returns read data exactly one cycle after a read strobe. The bench holds to both assumptions. Its memory model registers read data on the edge that ends the read cycle, and it lowers busGrant only after the controller has released the bus. It also changes configuration only while the controller is idle, so the addresses stay fixed for the whole of a transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAITBUS,
    S_READ,
    S_CAPTURE,
    S_WRITE
  } dmaState_t;

  typedef enum logic [1:0] {
    CFG_SRC  = 2'd0,
    CFG_DST  = 2'd1,
    CFG_CTRL = 2'd2
  } cfgSel_t;

  typedef struct packed {
    logic busReqOn;
    logic ackOn;
    logic issueRd;
    logic latchData;
    logic issueWr;
  } dmaStrobes_t;
endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        perReq,
  input  logic        busGrant,
  output dmaStrobes_t strobes
);
  dmaState_t state, nextState;
  logic armed;
  logic startXfer;

  assign startXfer = (state == S_IDLE) && enable && perReq && armed;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:    if (startXfer) nextState = S_WAITBUS;
      S_WAITBUS: if (busGrant) nextState = S_READ;
      S_READ:    nextState = S_CAPTURE;
      S_CAPTURE: nextState = S_WRITE;
      S_WRITE:   nextState = S_IDLE;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      armed <= 1'b1;
    end else begin
      state <= nextState;
      if (startXfer) armed <= 1'b0;
      else if (state == S_IDLE && !perReq) armed <= 1'b1;
    end
  end

  always_comb begin
    strobes.busReqOn  = (state != S_IDLE);
    strobes.ackOn     = (state == S_READ) || (state == S_CAPTURE) || (state == S_WRITE);
    strobes.issueRd   = (state == S_READ);
    strobes.latchData = (state == S_CAPTURE);
    strobes.issueWr   = (state == S_WRITE);
  end

  // R3: acknowledge only rises once the grant has been seen
  a_r3_ack_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.ackOn) |-> $past(busGrant));

  // R5: every write comes two cycles after a read
  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueWr |-> $past(strobes.issueRd, 2));

  // R4: read and write never share a cycle
  a_r4_one_bus_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.issueRd, strobes.issueWr}));
endmodule

// File: rtl/dma_dpath.sv
module dma_dpath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  dmaStrobes_t       strobes,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              enable
);
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic [DATA_W-1:0] dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      enable  <= 1'b0;
    end else if (cfgWe) begin
      unique case (cfgSel_t'(cfgSel))
        CFG_SRC:  srcAddr <= cfgData;
        CFG_DST:  dstAddr <= cfgData;
        CFG_CTRL: enable  <= cfgData[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataHold <= '0;
    else if (strobes.latchData) dataHold <= busRdata;
  end

  assign busAddr  = strobes.issueWr ? dstAddr : srcAddr;
  assign busWdata = dataHold;

  // R5: the written word is the one returned by the read
  a_r5_wdata_from_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueWr |-> busWdata == $past(busRdata));
endmodule

// File: rtl/dma_top.sv
module dma_top
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              perReq,
  output logic              perAck,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);
  dmaStrobes_t strobes;
  logic enable;

  dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .perReq(perReq),
    .busGrant(busGrant), .strobes(strobes)
  );

  dma_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .strobes(strobes), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .enable(enable)
  );

  assign busReq = strobes.busReqOn;
  assign perAck = strobes.ackOn;
  assign busRd  = strobes.issueRd;
  assign busWr  = strobes.issueWr;

  // R6: acknowledge and bus request end in the same cycle
  a_r6_release_together: assert property (@(posedge clk) disable iff (!rstN)
    $fell(perAck) |-> $fell(busReq));

  // R2, R7: a bus request only follows an enabled peripheral request
  a_r2_req_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> ($past(perReq) && $past(enable)));
endmodule

// File: tb/tb_dma_top.sv
module tb_dma_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic perReq = 1'b0;
  logic busGrant = 1'b0;
  logic perAck, busReq, busRd, busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata;

  logic [DATA_W-1:0] mem [0:255];
  logic preWe = 1'b0;
  logic [7:0] preAddr = '0;
  logic [DATA_W-1:0] preData = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dma_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .perReq(perReq), .perAck(perAck), .busReq(busReq), .busGrant(busGrant),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  always @(posedge clk) begin
    if (preWe) mem[preAddr] <= preData;
    if (busRd) busRdata <= mem[busAddr[7:0]];
    if (busWr) mem[busAddr[7:0]] <= busWdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic preload(input logic [7:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    preWe = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  // fields: src(16) dst(16) data(8) grant delay(8)
  localparam logic [47:0] VEC [4] = '{
    {16'h8000, 16'h0001, 8'hA5, 8'd0},
    {16'h8002, 16'h0003, 8'h3C, 8'd2},
    {16'h80FE, 16'h00FF, 8'hFF, 8'd3},
    {16'h1010, 16'h2020, 8'h00, 8'd1}
  };

  initial begin
    #400_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 busReq in reset", busReq, 0);
    check("R1 perAck in reset", perAck, 0);
    check("R1 strobes in reset", {busRd, busWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {busReq, perAck, busRd, busWr}, 0);

    // R7: disabled controller ignores requests
    perReq = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 disabled ignores req", {busReq, perAck}, 0);
    perReq = 1'b0;
    cfgWrite(2'd2, 16'h0001);

    for (int i = 0; i < 4; i++) begin
      logic [15:0] src, dst;
      logic [7:0] dat, dly;
      {src, dst, dat, dly} = VEC[i];
      cfgWrite(2'd0, src);
      cfgWrite(2'd1, dst);
      preload(src[7:0], dat);
      preload(dst[7:0], ~dat);
      @(negedge clk);
      perReq = 1'b1;
      @(negedge clk);
      check("R2 busReq raised", busReq, 1);
      check("R2 no early ack", perAck, 0);
      for (int k = 0; k < int'(dly); k++) begin
        @(negedge clk);
        check("R3 wait for grant", {perAck, busRd, busWr}, 0);
      end
      busGrant = 1'b1;
      @(negedge clk);
      check("R4 read strobe", busRd, 1);
      check("R4 ack with read", perAck, 1);
      check("R4 source address", busAddr, src);
      @(negedge clk);
      check("R5 capture cycle idle bus", {busRd, busWr}, 0);
      @(negedge clk);
      check("R5 write strobe", busWr, 1);
      check("R5 destination address", busAddr, dst);
      check("R5 write data", busWdata, dat);
      @(negedge clk);
      check("R6 release together", {busReq, perAck}, 0);
      check("R5 memory updated", mem[dst[7:0]], dat);
      busGrant = 1'b0;
      if (i == 1) begin
        repeat (5) @(negedge clk);
        check("R8 held req not rearmed", busReq, 0);
      end
      perReq = 1'b0;
      @(negedge clk);
    end

    // R8: a fresh request after a low cycle starts a new transfer
    perReq = 1'b1;
    @(negedge clk);
    check("R8 rearmed after low", busReq, 1);
    busGrant = 1'b1;
    repeat (4) @(negedge clk);
    busGrant = 1'b0;
    perReq = 1'b0;
    // R7: clearing enable blocks further transfers
    cfgWrite(2'd2, 16'h0000);
    perReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 cleared enable blocks req", busReq, 0);
    perReq = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule